// File: doc/BRIEF.md
# Programming Data CRC-16 Accumulator

This block holds a 16-bit cyclic redundancy check over the data bytes that an in-system programming engine accepts while it writes flash. After a long transfer the host reads the single register value instead of reading back every byte it wrote. The transaction engine decides which bytes qualify, and it raises the update strobe only for those: acknowledged program data. Address bytes, dummy bytes of erase commands and refused bytes never reach the strobe. Every flash target feeds the same register.

Each update folds one whole byte into the register in a single clock. Inside that clock the eight bit steps are unrolled, most significant data bit first. On each step the feedback bit is the register's top bit XORed with the incoming data bit. The register then shifts left, and when the feedback bit is 1 it is XORed with the polynomial 0x1021. A synchronous reset or a clear strobe loads the register with all ones. If clear and update come in the same cycle, clear wins.

Top module: `isp_crc_accum`

## Requirements
- R1: While `rst` is high at a rising clock edge, `crc_o` becomes 0xFFFF at that edge.
- R2: When `clr_i` is high at a rising edge, `crc_o` is 0xFFFF after that edge, whatever its previous value.
- R3: When `upd_i` is high and `clr_i` is low at a rising edge, `crc_o` after that edge is the old value with the 8 bits of `data_i` folded in, bit 7 first. For each bit, fb = crc[15] XOR bit, crc = crc << 1, and crc ^= 0x1021 when fb is 1.
- R4: When neither `clr_i` nor `upd_i` is high at a rising edge, `crc_o` keeps its value, and any change on `data_i` has no effect.
- R5: When `clr_i` and `upd_i` are both high at the same edge, the result is 0xFFFF and `data_i` is ignored.
- R6: Updates on back-to-back cycles each fold in one byte, with no lost or repeated byte.
- R7: Starting from 0xFFFF, the ASCII bytes "123456789" fed in order leave `crc_o` at 0x29B1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, seeds all ones |
| clr_i | input | 1 | Clear strobe, reloads all ones; has priority |
| upd_i | input | 1 | Update strobe, folds `data_i` into the register |
| data_i | input | 8 | Accepted data byte |
| crc_o | output | 16 | Current register value |

## Verification
Clear and update are the two functions that can fall in the same cycle. The bench raises both strobes together, with non-zero data and with the register far from its seed. The result must be 0xFFFF, not the byte folded into the old value or into the seed. The bench also puts a clear directly between updates on adjacent cycles. This shows that the priority neither drops the following byte nor leaks the previous one.

// File: rtl/isp_crc_pkg.sv
package isp_crc_pkg;

    localparam int          CRC_W    = 16;
    localparam int          BYTE_W   = 8;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [1:0] {
        CRC_ACT_HOLD  = 2'd0,
        CRC_ACT_SEED  = 2'd1,
        CRC_ACT_FOLD  = 2'd2
    } crc_act_e;

    typedef struct packed {
        crc_act_e    act;
        logic [7:0]  byte_q;
    } crc_cmd_t;

endpackage

// File: rtl/isp_crc_ctrl.sv
module isp_crc_ctrl
    import isp_crc_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] data_i,
    output crc_act_e          act_o,
    output logic [DATA_W-1:0] byte_o
);

    // Clear outranks update; the byte is forwarded only when it is folded.
    always_comb begin
        if (clr_i) begin
            act_o  = CRC_ACT_SEED;
            byte_o = '0;
        end else if (upd_i) begin
            act_o  = CRC_ACT_FOLD;
            byte_o = data_i;
        end else begin
            act_o  = CRC_ACT_HOLD;
            byte_o = '0;
        end
    end

    always_comb begin
        AST_CLEAR_FIRST: assert (!(clr_i && act_o == CRC_ACT_FOLD)); // R5
    end

endmodule

// File: rtl/isp_crc_step.sv
module isp_crc_step
    import isp_crc_pkg::*;
#(
    parameter int              W      = CRC_W,
    parameter int              DATA_W = BYTE_W,
    parameter logic [W-1:0]    POLY   = CRC_POLY
) (
    input  logic [W-1:0]      crc_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic [W-1:0]      crc_o
);

    localparam int LAST = DATA_W;

    logic [W-1:0] stage [0:LAST];

    assign stage[0] = crc_i;

    // One stage per data bit, most significant bit first.
    for (genvar k = 0; k < DATA_W; k++) begin : g_bit
        logic fb;
        assign fb           = stage[k][W-1] ^ byte_i[DATA_W-1-k];
        assign stage[k+1]   = {stage[k][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_o = stage[LAST];

endmodule

// File: rtl/isp_crc_accum.sv
module isp_crc_accum
    import isp_crc_pkg::*;
#(
    parameter int              W      = CRC_W,
    parameter int              DATA_W = BYTE_W,
    parameter logic [W-1:0]    POLY   = CRC_POLY,
    parameter logic [W-1:0]    SEED   = CRC_SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [W-1:0]      crc_o
);

    crc_act_e          act;
    logic [DATA_W-1:0] fold_byte;
    logic [W-1:0]      crc_q;
    logic [W-1:0]      crc_next;

    isp_crc_ctrl #(
        .DATA_W (DATA_W)
    ) ctrl_i (
        .clr_i  (clr_i),
        .upd_i  (upd_i),
        .data_i (data_i),
        .act_o  (act),
        .byte_o (fold_byte)
    );

    isp_crc_step #(
        .W      (W),
        .DATA_W (DATA_W),
        .POLY   (POLY)
    ) step_i (
        .crc_i  (crc_q),
        .byte_i (fold_byte),
        .crc_o  (crc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= SEED;
        end else begin
            case (act)
                CRC_ACT_SEED: crc_q <= SEED;
                CRC_ACT_FOLD: crc_q <= crc_next;
                default:      crc_q <= crc_q;
            endcase
        end
    end

    assign crc_o = crc_q;

    AST_RESET_SEED: assert property (@(posedge clk)
        rst |=> crc_o == SEED); // R1

    AST_CLEAR_SEED: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> crc_o == SEED); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !upd_i) |=> $stable(crc_o)); // R4

    AST_FOLD_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !clr_i) |=> crc_o == $past(crc_next)); // R3

endmodule

// File: tb/isp_crc_accum_tb.sv
module isp_crc_accum_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        clr_i;
    logic        upd_i;
    logic [7:0]  data_i;
    logic [15:0] crc_o;

    int checks = 0;
    int errors = 0;
    int model;

    always #5 clk = ~clk;

    isp_crc_accum dut_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_i),
        .upd_i  (upd_i),
        .data_i (data_i),
        .crc_o  (crc_o)
    );

    function automatic int fold(input int c, input int d);
        int r = c;
        for (int i = 7; i >= 0; i--) begin
            int fb = ((r >> 15) & 1) ^ ((d >> i) & 1);
            r = (r << 1) & 16'hFFFF;
            if (fb != 0) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic check(input string req, input int expv);
        checks++;
        if (int'(crc_o) != expv) begin
            errors++;
            $display("FAIL %s: crc_o=%04h expected=%04h", req, crc_o, expv[15:0]);
        end
    endtask

    // Drive one cycle, update the model, compare after the edge.
    task automatic cyc(input logic r, input logic c, input logic u,
                       input int d, input string req);
        @(negedge clk);
        rst = r; clr_i = c; upd_i = u; data_i = d[7:0];
        if (r || c) model = 16'hFFFF;
        else if (u) model = fold(model, d);
        @(posedge clk);
        #1;
        check(req, model);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        byte unsigned msg [9] = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
        rst = 1'b1; clr_i = 1'b0; upd_i = 1'b0; data_i = 8'h00; model = 16'hFFFF;
        cyc(1'b1, 1'b0, 1'b0, 0, "R1");
        cyc(1'b1, 1'b0, 1'b1, 8'hA5, "R1");

        // R7 known vector, back-to-back (R6)
        for (int i = 0; i < 9; i++) cyc(1'b0, 1'b0, 1'b1, int'(msg[i]), "R6");
        checks++;
        if (crc_o != 16'h29B1) begin
            errors++;
            $display("FAIL R7: crc_o=%04h expected=29b1", crc_o);
        end

        // R4 idle with wiggling data
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 8'h5A ^ i, "R4");

        // R2 clear from non-seed value
        cyc(1'b0, 1'b1, 1'b0, 8'h00, "R2");

        // R3 assorted patterns
        cyc(1'b0, 1'b0, 1'b1, 8'h00, "R3");
        cyc(1'b0, 1'b0, 1'b1, 8'hFF, "R3");
        cyc(1'b0, 1'b0, 1'b1, 8'h80, "R3");
        cyc(1'b0, 1'b0, 1'b1, 8'h01, "R3");
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b0, (i % 3) != 0, (i * 37 + 11) & 255, "R3");

        // R5 clear+update collide, between adjacent updates
        cyc(1'b0, 1'b0, 1'b1, 8'hC3, "R6");
        cyc(1'b0, 1'b1, 1'b1, 8'h7E, "R5");
        cyc(1'b0, 1'b0, 1'b1, 8'h3C, "R6");
        cyc(1'b0, 1'b1, 1'b1, 8'hFF, "R5");
        cyc(1'b0, 1'b0, 1'b0, 8'h12, "R4");

        // reset mid-stream
        cyc(1'b0, 1'b0, 1'b1, 8'h99, "R3");
        cyc(1'b1, 1'b0, 1'b1, 8'h44, "R1");
        cyc(1'b0, 1'b0, 1'b1, 8'h44, "R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule